// File: doc/BRIEF.md
# Wakeup Event Status Controller

This block gathers a small set of wakeup sources for a standby domain and turns them into two outputs: a level power-up request for the power sequencer and an interrupt line. The sources are a modem ring input (active low, asynchronous), an infrared address-match strobe from an external detector, and a parameterised number of auxiliary event strobes. Every detected event sets a sticky status bit. That bit stays set until software clears it, and the enable bit has no effect on it.

Software reaches the block through a plain register port. Three registers, each one bit per event, hold the status, the power-up enables and the interrupt route enables. The power-up request is the OR of pending-and-enabled events. The interrupt is the OR of pending-and-routed events. The register set lives in the always-powered domain. It is cleared by the asynchronous power-on reset or by a synchronous software reset. The ordinary hardware reset leaves it untouched and only returns the ring synchronizer to idle.

Top module: `wake_event_ctrl`

## Requirements
- R1: Event bit positions are fixed: bit 0 is the ring event, bit 1 is the infrared match, and bits 2 and up are the auxiliary strobes in order. `reg_addr` 0 selects status, 1 selects the power-up enables, 2 selects the interrupt route enables, and 3 reads as zero and ignores writes.
- R2: An event input that is active at a clock edge sets its status bit at that edge, whatever its enable bit holds.
- R3: `pwr_req` is 1 exactly when some bit position has both status and enable equal to 1.
- R4: Writing an enable bit to 0 removes that event's contribution to `pwr_req` and leaves every status bit unchanged.
- R5: `irq` is 1 exactly when some bit position has both status and route enable equal to 1. The power-up enables do not affect it.
- R6: Writing 1 to a status bit clears it, and writing 0 to a status bit leaves it as it is. If an event arrives in the same cycle as the clear, the bit stays set.
- R7: The ring input is active low and passes through two synchronizing flops. Only a falling edge is an event. The status bit reads 1 after the third rising clock edge following the fall, and a ring input held low raises no further event.
- R8: `sw_rst` clears all three registers at the next clock edge and takes priority over events and writes. `por_n` low clears them asynchronously.
- R9: `hw_rst` changes no status, enable or route bit.
- R10: An enable or route write stores the whole write word at the clock edge, and the outputs reflect the new value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sw_rst | input | 1 | Synchronous software reset of the register set |
| hw_rst | input | 1 | Hardware reset; only idles the ring synchronizer |
| ring_n | input | 1 | Modem ring indication, active low, asynchronous |
| ir_match | input | 1 | Infrared address-match strobe, synchronous |
| aux_evt | input | N_AUX (2) | Further event strobes, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | N_EVT (4) | Write data, one bit per event |
| reg_rdata | output | N_EVT (4) | Read data of the selected register |
| pwr_req | output | 1 | Level power-up request |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status clear and a new event landing on the same edge. The bench sets bits with strobes, then raises the infrared strobe in the very cycle it issues a write-one-to-clear covering that bit and a second, quiet bit. It checks that the active bit survives and the quiet one clears. It also builds every status pattern, including the ring bit, through the ring synchronizer's three-edge path. For each pattern it sweeps all enable and route words, so every combination of the two OR reductions is observed.

// File: rtl/wkc_pkg.sv
package wkc_pkg;
  typedef enum logic [1:0] {
    WK_STAT  = 2'd0,
    WK_ENA   = 2'd1,
    WK_ROUTE = 2'd2,
    WK_RSVD  = 2'd3
  } wk_sel_e;

  localparam int RING_POS = 0;
  localparam int IR_POS   = 1;
  localparam int AUX_BASE = 2;
endpackage

// File: rtl/wkc_ring_sync.sv
module wkc_ring_sync (
  input  logic clk,
  input  logic por_n,
  input  logic hw_rst,
  input  logic ring_n,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else if (hw_rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= ring_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // one-cycle pulse on the synchronized high-to-low transition
  assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/wkc_evt_cell.sv
module wkc_evt_cell (
  input  logic clk,
  input  logic por_n,
  input  logic sw_rst,
  input  logic evt_i,
  input  logic clr_i,
  input  logic en_we,
  input  logic en_d,
  input  logic rt_we,
  input  logic rt_d,
  output logic stat_o,
  output logic en_o,
  output logic rt_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stat_o <= 1'b0;
      en_o   <= 1'b0;
      rt_o   <= 1'b0;
    end else if (sw_rst) begin
      stat_o <= 1'b0;
      en_o   <= 1'b0;
      rt_o   <= 1'b0;
    end else begin
      // a fresh event outranks a same-cycle clear
      stat_o <= evt_i | (stat_o & ~clr_i);
      if (en_we) en_o <= en_d;
      if (rt_we) rt_o <= rt_d;
    end
  end
endmodule

// File: rtl/wkc_req_merge.sv
module wkc_req_merge #(
  parameter int N_EVT = 4
) (
  input  logic [N_EVT-1:0] stat_i,
  input  logic [N_EVT-1:0] en_i,
  input  logic [N_EVT-1:0] rt_i,
  output logic             pwr_req_o,
  output logic             irq_o
);
  assign pwr_req_o = |(stat_i & en_i);
  assign irq_o     = |(stat_i & rt_i);
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wkc_pkg::*;
#(
  parameter  int N_AUX = 2,
  localparam int N_EVT = N_AUX + 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sw_rst,
  input  logic             hw_rst,
  input  logic             ring_n,
  input  logic             ir_match,
  input  logic [N_AUX-1:0] aux_evt,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [N_EVT-1:0] reg_wdata,
  output logic [N_EVT-1:0] reg_rdata,
  output logic             pwr_req,
  output logic             irq
);
  logic             ring_fall;
  logic [N_EVT-1:0] ev_hit, stat_q, en_q, route_q;
  wk_sel_e          sel;
  logic             wr_stat, wr_en, wr_rt;

  wkc_ring_sync u_ring (
    .clk    (clk),
    .por_n  (por_n),
    .hw_rst (hw_rst),
    .ring_n (ring_n),
    .fall_o (ring_fall)
  );

  always_comb begin
    ev_hit                          = '0;
    ev_hit[RING_POS]                = ring_fall;
    ev_hit[IR_POS]                  = ir_match;
    ev_hit[AUX_BASE +: N_AUX]       = aux_evt;
  end

  assign sel     = wk_sel_e'(reg_addr);
  assign wr_stat = reg_wr && (sel == WK_STAT);
  assign wr_en   = reg_wr && (sel == WK_ENA);
  assign wr_rt   = reg_wr && (sel == WK_ROUTE);

  for (genvar i = 0; i < N_EVT; i++) begin : g_cell
    wkc_evt_cell u_cell (
      .clk    (clk),
      .por_n  (por_n),
      .sw_rst (sw_rst),
      .evt_i  (ev_hit[i]),
      .clr_i  (wr_stat & reg_wdata[i]),
      .en_we  (wr_en),
      .en_d   (reg_wdata[i]),
      .rt_we  (wr_rt),
      .rt_d   (reg_wdata[i]),
      .stat_o (stat_q[i]),
      .en_o   (en_q[i]),
      .rt_o   (route_q[i])
    );
  end

  wkc_req_merge #(.N_EVT(N_EVT)) u_merge (
    .stat_i    (stat_q),
    .en_i      (en_q),
    .rt_i      (route_q),
    .pwr_req_o (pwr_req),
    .irq_o     (irq)
  );

  always_comb begin
    unique case (sel)
      WK_STAT:  reg_rdata = stat_q;
      WK_ENA:   reg_rdata = en_q;
      WK_ROUTE: reg_rdata = route_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wkc_chk.sv
module wkc_chk #(
  parameter int N_EVT = 4
) (
  input logic             clk,
  input logic             por_n,
  input logic             sw_rst,
  input logic             hw_rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [N_EVT-1:0] ev_hit,
  input logic [N_EVT-1:0] stat_q,
  input logic [N_EVT-1:0] en_q,
  input logic [N_EVT-1:0] route_q,
  input logic             pwr_req,
  input logic             irq
);
  // R2
  evt_sets_status_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ev_hit != '0 && !sw_rst) |=> ((stat_q & $past(ev_hit)) == $past(ev_hit)));

  // R3
  req_needs_pending_chk: assert property (@(posedge clk) disable iff (!por_n)
    pwr_req |-> ((stat_q & en_q) != '0));

  // R4
  en_write_keeps_status_chk: assert property (@(posedge clk) disable iff (!por_n)
    (reg_wr && reg_addr == 2'd1 && !sw_rst && ev_hit == '0) |=> (stat_q == $past(stat_q)));

  // R5
  irq_needs_route_chk: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> ((stat_q & route_q) != '0));

  // R8
  sw_reset_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> (stat_q == '0 && en_q == '0 && route_q == '0));

  // R9
  hw_reset_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
    (hw_rst && !sw_rst && !reg_wr && ev_hit == '0)
      |=> (stat_q == $past(stat_q) && en_q == $past(en_q) && route_q == $past(route_q)));
endmodule

bind wake_event_ctrl wkc_chk #(.N_EVT(N_EVT)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .sw_rst   (sw_rst),
  .hw_rst   (hw_rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .ev_hit   (ev_hit),
  .stat_q   (stat_q),
  .en_q     (en_q),
  .route_q  (route_q),
  .pwr_req  (pwr_req),
  .irq      (irq)
);

// File: tb/sim_wake_event_ctrl.sv
`timescale 1ns/1ps
module sim_wake_event_ctrl;
  localparam int NA = 2;
  localparam int NE = NA + 2;

  logic          clk = 1'b0;
  logic          por_n, sw_rst, hw_rst, ring_n, ir_match, reg_wr;
  logic [NA-1:0] aux_evt;
  logic [1:0]    reg_addr;
  logic [NE-1:0] reg_wdata, reg_rdata;
  logic          pwr_req, irq;
  int            nvec = 0, nbad = 0;

  always #2.5 clk = ~clk;

  wake_event_ctrl #(.N_AUX(NA)) u0 (
    .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .hw_rst(hw_rst),
    .ring_n(ring_n), .ir_match(ir_match), .aux_evt(aux_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwr_req(pwr_req), .irq(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [NE-1:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [NE-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic swr();
    sw_rst = 1'b1; step(1); sw_rst = 1'b0;
  endtask

  // bit0 ring, bit1 ir, bits 3:2 aux (R1)
  task automatic set_stat(input logic [NE-1:0] s);
    if (s[0]) begin
      ring_n = 1'b0; step(3); ring_n = 1'b1; step(1);
    end
    ir_match = s[1]; aux_evt = s[3:2];
    step(1);
    ir_match = 1'b0; aux_evt = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [NE-1:0] d;
    por_n = 1'b0; sw_rst = 1'b0; hw_rst = 1'b0; ring_n = 1'b1; ir_match = 1'b0;
    aux_evt = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    step(3);
    por_n = 1'b1;
    step(1);

    // R8 reset state
    rd(0, d); chk("R8 por status", d, 0);
    rd(1, d); chk("R8 por enable", d, 0);
    rd(2, d); chk("R8 por route", d, 0);
    chk("R8 por pwr_req", pwr_req, 0);
    chk("R8 por irq", irq, 0);

    // R2 R3 R4 R5 R10 sweep of status x enable x route
    for (int s = 0; s < 16; s++) begin
      swr();
      set_stat(s[NE-1:0]);
      rd(0, d); chk("R2 status set with enables clear", d, s);
      for (int e = 0; e < 16; e++) begin
        wr(1, e[NE-1:0]);
        rd(1, d); chk("R10 enable store", d, e);
        rd(0, d); chk("R4 status kept over enable write", d, s);
        for (int r = 0; r < 16; r++) begin
          wr(2, r[NE-1:0]);
          chk("R3 pwr_req", pwr_req, ((s & e) != 0));
          chk("R5 irq", irq, ((s & r) != 0));
        end
      end
    end

    // R6 W1C sweep
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        swr();
        set_stat(s[NE-1:0]);
        wr(0, c[NE-1:0]);
        rd(0, d); chk("R6 w1c", d, s & ~c);
      end
    end

    // R6 set wins over same-cycle clear
    swr();
    set_stat(4'b0110);
    ir_match = 1'b1;
    wr(0, 4'b0110);
    ir_match = 1'b0;
    rd(0, d); chk("R6 set beats clear", d, 4'b0010);

    // R4 clearing enable drops request, status stays
    swr();
    set_stat(4'b1000);
    wr(1, 4'b1000);
    chk("R4 request when enabled", pwr_req, 1);
    wr(1, 4'b0000);
    chk("R4 request blocked", pwr_req, 0);
    rd(0, d); chk("R4 status unchanged", d, 4'b1000);

    // R7 ring latency and level-hold
    swr();
    ring_n = 1'b0;
    step(2);
    rd(0, d); chk("R7 ring not yet after two edges", d, 0);
    step(1);
    rd(0, d); chk("R7 ring seen after third edge", d, 4'b0001);
    wr(0, 4'b0001);
    step(10);
    rd(0, d); chk("R7 held low no refire", d, 0);
    ring_n = 1'b1;
    step(5);
    rd(0, d); chk("R7 rising edge ignored", d, 0);

    // R1 reserved address
    swr();
    set_stat(4'b0101);
    wr(3, 4'b1111);
    rd(3, d); chk("R1 reserved reads zero", d, 0);
    rd(0, d); chk("R1 reserved write no effect status", d, 4'b0101);
    rd(1, d); chk("R1 reserved write no effect enable", d, 0);

    // R9 hardware reset holds registers
    swr();
    set_stat(4'b1010);
    wr(1, 4'b0101); wr(2, 4'b0011);
    hw_rst = 1'b1; step(3); hw_rst = 1'b0; step(1);
    rd(0, d); chk("R9 status kept", d, 4'b1010);
    rd(1, d); chk("R9 enable kept", d, 4'b0101);
    rd(2, d); chk("R9 route kept", d, 4'b0011);
    chk("R9 irq kept", irq, 1);

    // R8 software reset beats event; por clears asynchronously
    wr(1, 4'b1111);
    sw_rst = 1'b1; ir_match = 1'b1; step(1); sw_rst = 1'b0; ir_match = 1'b0;
    rd(0, d); chk("R8 sw reset status", d, 0);
    rd(1, d); chk("R8 sw reset enable", d, 0);
    set_stat(4'b0110); wr(1, 4'b0110);
    #1 por_n = 1'b0; #0.5;
    chk("R8 por async pwr_req", pwr_req, 0);
    rd(0, d); chk("R8 por async status", d, 0);
    step(1); por_n = 1'b1; step(1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule